// File: doc/BRIEF.md
# Comparator Timer Channel

This block is a single channel of an event timer. A free-running main counter is fed in from outside. The channel compares that counter against its own stored comparator and emits a one-cycle expiry strobe when the counter reaches the comparator. It also holds a period register. In one-shot mode a match fires once. In periodic mode each match moves the comparator forward by the period, so the channel fires again one period later.

A narrow mode restricts the channel to the lower half of the counter width. In this mode the comparison uses only the low halves, and the upper halves of the comparator and the period are held at zero. A channel that is in narrow mode and one-shot mode also fires when the low half of the counter reaches all ones, which gives software a wrap notice.

Software writes the comparator one half at a time through two write strobes. In periodic mode those writes are steered to the period register instead, unless a one-time set-value flag has been armed beforehand. Decoding register addresses and routing the interrupt are left to neighbouring blocks.

Top module: `evt_chan`

## Requirements
- R1: After reset the comparator holds all ones, the period holds zero, the set-value flag is clear and `expire` is low.
- R2: A comparator whose full-width value is all ones is unprogrammed: it never produces a match, whatever the counter does.
- R3: A match exists when (comparator − counter), taken as a signed number, is zero or negative. When a match first appears at a clock edge, `expire` is high for exactly the next cycle. A one-shot match then stays silent while it persists.
- R4: `wr_lo` writes bits [HW-1:0] and `wr_hi` writes bits [CW-1:HW] of the destination. The destination is the comparator when the channel is one-shot or the set-value flag is armed. Otherwise the destination is the period.
- R5: In wide mode the difference is signed over the full counter width. A counter more than half the range ahead of the comparator therefore counts as behind it and does not match.
- R6: `arm_set` sets the set-value flag. Any `wr_lo` or `wr_hi` write clears the flag, whichever register that write lands in.
- R7: In periodic mode with a nonzero period, each cycle with a match adds the period to the comparator. While the counter is still past the comparator, the comparator keeps advancing by one period per cycle, and this whole catch-up produces a single strobe. A strobe follows every time a match is restored after the comparator has moved ahead. A period of zero leaves the comparator unchanged.
- R8: Writes to the period clear the top bit of the written data for the upper half in either mode, and for the lower half in narrow mode. The period's most significant bit is therefore always zero.
- R9: While `cfg_narrow` is high, the upper halves of the comparator and the period become zero one edge later and stay zero. This includes dropping `wr_hi` writes.
- R10: In narrow mode the signed difference uses only the low HW bits of the comparator and the counter.
- R11: In narrow one-shot mode, a counter whose low half is all ones raises its own strobe. This wrap strobe does not occur in periodic mode or in wide mode.
- R12: While `glb_en` is low, there are no matches, no strobes and no comparator advance. A match that is already present when `glb_en` rises fires on that edge.
- R13: A write that lands in the comparator re-arms detection. If the new value is already reached, a fresh strobe follows one cycle after the write's strobe slot.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| glb_en | input | 1 | Global enable for matching and advance |
| counter | input | CW | Main counter value |
| cfg_periodic | input | 1 | 1 = periodic, 0 = one-shot |
| cfg_narrow | input | 1 | 1 = half-width mode |
| arm_set | input | 1 | Arm the set-value flag |
| wr_lo | input | 1 | Write strobe, lower half |
| wr_hi | input | 1 | Write strobe, upper half |
| wr_data | input | HW | Write data for one half |
| expire | output | 1 | One-cycle expiry strobe |
| cmp_q | output | CW | Current comparator |
| period_q | output | CW | Current period |
| armed | output | 1 | Set-value flag |

## Verification
The bench uses a 16-bit counter and sweeps the counter past chosen comparator values. It predicts the strobe arithmetically from the signed difference and from the period phase, for periods 1 to 6. A design that compares unsigned would fire on a counter that has jumped half the range ahead. A design that loses the edge state would miss the back-to-back strobes at period 1, or strobe on every cycle of a catch-up. Directed cases cover the remaining rules:
- a jump far past the comparator, which must advance the comparator to the exact phase;
- a zero period;
- the unprogrammed all-ones comparator;
- write steering through the set-value flag;
- clamping of the period's top bit;
- truncation when narrow mode starts;
- the low-half wrap strobe, which must be absent in periodic and wide modes;
- a re-write after a match, which must fire again.

// File: rtl/evt_chan_pkg.sv
package evt_chan_pkg;

  // Where a half-word write lands
  typedef enum logic {
    DST_CMP = 1'b0,
    DST_PER = 1'b1
  } wr_dst_e;

  localparam int unsigned NUM_CMP = 2;  // current comparator, stepped comparator

endpackage

// File: rtl/evt_chan_cmp.sv
// Signed "reached" test: ref_val - cnt <= 0 in the active width.
module evt_chan_cmp #(
  parameter int unsigned CW = 64
) (
  input  logic [CW-1:0] cnt,
  input  logic [CW-1:0] ref_val,
  input  logic          narrow,
  output logic          reached
);
  localparam int unsigned HW = CW / 2;

  logic [CW-1:0] diff_w;
  logic [HW-1:0] diff_n;

  always_comb begin
    diff_w = ref_val - cnt;
    diff_n = ref_val[HW-1:0] - cnt[HW-1:0];
    if (narrow) reached = diff_n[HW-1] | (diff_n == '0);
    else        reached = diff_w[CW-1] | (diff_w == '0);
  end
endmodule

// File: rtl/evt_chan_store.sv
// Comparator, period and set-value flag storage with write steering.
module evt_chan_store
  import evt_chan_pkg::*;
#(
  parameter int unsigned CW = 64
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                narrow,
  input  logic                periodic,
  input  logic                arm_set,
  input  logic                wr_lo,
  input  logic                wr_hi,
  input  logic [CW/2-1:0]     wr_data,
  input  logic                do_adv,
  output logic [CW-1:0]       cmp_q,
  output logic [CW-1:0]       period_q,
  output logic                armed_q,
  output logic [CW-1:0]       cmp_step,
  output logic                per_nz,
  output logic                cmp_wr
);
  localparam int unsigned HW = CW / 2;

  wr_dst_e       dst;
  logic          any_wr;
  logic          per_wr;
  logic [CW-1:0] cmp_n;
  logic [CW-1:0] per_n;
  logic          armed_n;
  logic          cmp_en;
  logic          per_en;
  logic [HW-1:0] step_lo;

  always_comb begin
    dst     = (!periodic || armed_q) ? DST_CMP : DST_PER;
    any_wr  = wr_lo | wr_hi;
    cmp_wr  = any_wr & (dst == DST_CMP);
    per_wr  = any_wr & (dst == DST_PER);
    step_lo = cmp_q[HW-1:0] + period_q[HW-1:0];
    per_nz  = narrow ? (|period_q[HW-1:0]) : (|period_q);
    if (narrow) cmp_step = {{HW{1'b0}}, step_lo};
    else        cmp_step = cmp_q + period_q;
  end

  // Comparator next state
  always_comb begin
    cmp_n = cmp_q;
    if (cmp_wr) begin
      if (wr_lo) cmp_n[HW-1:0]  = wr_data;
      if (wr_hi) cmp_n[CW-1:HW] = wr_data;
    end else if (do_adv) begin
      cmp_n = cmp_step;
    end
    if (narrow) cmp_n[CW-1:HW] = '0;
    cmp_en = cmp_wr | do_adv | narrow;
  end

  // Period next state, with top-bit clamp
  always_comb begin
    per_n = period_q;
    if (per_wr) begin
      if (wr_lo) per_n[HW-1:0]  = narrow ? {1'b0, wr_data[HW-2:0]} : wr_data;
      if (wr_hi) per_n[CW-1:HW] = {1'b0, wr_data[HW-2:0]};
    end
    if (narrow) per_n[CW-1:HW] = '0;
    per_en = per_wr | narrow;
  end

  // Set-value flag: set wins, any half write consumes it
  always_comb begin
    if (arm_set)     armed_n = 1'b1;
    else if (any_wr) armed_n = 1'b0;
    else             armed_n = armed_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cmp_q    <= '1;
      period_q <= '0;
      armed_q  <= 1'b0;
    end else begin
      if (cmp_en) cmp_q    <= cmp_n;
      if (per_en) period_q <= per_n;
      armed_q <= armed_n;
    end
  end
endmodule

// File: rtl/evt_chan_edge.sv
// Rising-edge detection of match and wrap conditions, registered strobe.
module evt_chan_edge (
  input  logic clk,
  input  logic rst_n,
  input  logic hit,
  input  logic wrap,
  input  logic hit_clr,
  output logic expire
);
  logic hit_q, wrap_q;
  logic hit_n, wrap_n, exp_n;

  always_comb begin
    exp_n  = (hit & ~hit_q) | (wrap & ~wrap_q);
    hit_n  = hit_clr ? 1'b0 : hit;
    wrap_n = wrap;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hit_q  <= 1'b0;
      wrap_q <= 1'b0;
      expire <= 1'b0;
    end else begin
      hit_q  <= hit_n;
      wrap_q <= wrap_n;
      expire <= exp_n;
    end
  end
endmodule

// File: rtl/evt_chan.sv
module evt_chan
  import evt_chan_pkg::*;
#(
  parameter int unsigned CW = 64
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            glb_en,
  input  logic [CW-1:0]   counter,
  input  logic            cfg_periodic,
  input  logic            cfg_narrow,
  input  logic            arm_set,
  input  logic            wr_lo,
  input  logic            wr_hi,
  input  logic [CW/2-1:0] wr_data,
  output logic            expire,
  output logic [CW-1:0]   cmp_q,
  output logic [CW-1:0]   period_q,
  output logic            armed
);
  localparam int unsigned HW = CW / 2;

  logic [CW-1:0]      cmp_step;
  logic               per_nz;
  logic               cmp_wr;
  logic               do_adv;
  logic [CW-1:0]      cmp_ref [NUM_CMP];
  logic [NUM_CMP-1:0] reach;
  logic               unprog;
  logic               hit;
  logic               wrap;
  logic               hit_clr;

  evt_chan_store #(.CW(CW)) u_store (
    .clk      (clk),
    .rst_n    (rst_n),
    .narrow   (cfg_narrow),
    .periodic (cfg_periodic),
    .arm_set  (arm_set),
    .wr_lo    (wr_lo),
    .wr_hi    (wr_hi),
    .wr_data  (wr_data),
    .do_adv   (do_adv),
    .cmp_q    (cmp_q),
    .period_q (period_q),
    .armed_q  (armed),
    .cmp_step (cmp_step),
    .per_nz   (per_nz),
    .cmp_wr   (cmp_wr)
  );

  assign cmp_ref[0] = cmp_q;
  assign cmp_ref[1] = cmp_step;

  for (genvar g = 0; g < NUM_CMP; g++) begin : g_cmp
    evt_chan_cmp #(.CW(CW)) u_cmp (
      .cnt     (counter),
      .ref_val (cmp_ref[g]),
      .narrow  (cfg_narrow),
      .reached (reach[g])
    );
  end

  always_comb begin
    unprog  = (cmp_q == {CW{1'b1}});
    hit     = glb_en & reach[0] & ~unprog;
    wrap    = glb_en & cfg_narrow & ~cfg_periodic & (&counter[HW-1:0]);
    do_adv  = hit & cfg_periodic & per_nz & ~cmp_wr;
    // Re-arm the edge detector when the comparator moves ahead of the counter
    hit_clr = cmp_wr | (do_adv & ~reach[1]);
  end

  evt_chan_edge u_edge (
    .clk     (clk),
    .rst_n   (rst_n),
    .hit     (hit),
    .wrap    (wrap),
    .hit_clr (hit_clr),
    .expire  (expire)
  );
endmodule

// File: rtl/evt_chan_chk.sv
module evt_chan_chk #(
  parameter int unsigned CW = 64
) (
  input logic          clk,
  input logic          rst_n,
  input logic          glb_en,
  input logic          cfg_periodic,
  input logic          cfg_narrow,
  input logic          arm_set,
  input logic          wr_lo,
  input logic          wr_hi,
  input logic          expire,
  input logic [CW-1:0] cmp_q,
  input logic [CW-1:0] period_q,
  input logic          armed
);
  localparam int unsigned HW = CW / 2;

  assert_unprog_silent_R2: assert property (@(posedge clk) disable iff (!rst_n)
    expire |-> ($past(cmp_q) != {CW{1'b1}}) || $past(cfg_narrow));

  assert_period_steer_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (!glb_en && wr_lo && !wr_hi && cfg_periodic && !armed && !cfg_narrow)
      |=> $stable(cmp_q));

  assert_arm_clear_R6: assert property (@(posedge clk) disable iff (!rst_n)
    ((wr_lo || wr_hi) && !arm_set) |=> !armed);

  assert_period_msb_R8: assert property (@(posedge clk) disable iff (!rst_n)
    period_q[CW-1] == 1'b0);

  assert_narrow_upper_R9: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_narrow |=> (cmp_q[CW-1:HW] == '0) && (period_q[CW-1:HW] == '0));

  assert_enable_gate_R12: assert property (@(posedge clk) disable iff (!rst_n)
    expire |-> $past(glb_en));

  assert_idle_hold_R12: assert property (@(posedge clk) disable iff (!rst_n)
    (!glb_en && !wr_lo && !wr_hi && !cfg_narrow) |=> $stable(cmp_q));
endmodule

bind evt_chan evt_chan_chk #(.CW(CW)) u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .glb_en       (glb_en),
  .cfg_periodic (cfg_periodic),
  .cfg_narrow   (cfg_narrow),
  .arm_set      (arm_set),
  .wr_lo        (wr_lo),
  .wr_hi        (wr_hi),
  .expire       (expire),
  .cmp_q        (cmp_q),
  .period_q     (period_q),
  .armed        (armed)
);

// File: tb/evt_chan_bench.sv
`timescale 1ns/1ps
module evt_chan_bench;
  localparam int unsigned CW = 16;
  localparam int unsigned HW = CW / 2;

  logic          clk = 1'b0;
  logic          rst_n;
  logic          glb_en;
  logic [CW-1:0] counter;
  logic          cfg_periodic;
  logic          cfg_narrow;
  logic          arm_set;
  logic          wr_lo;
  logic          wr_hi;
  logic [HW-1:0] wr_data;
  logic          expire;
  logic [CW-1:0] cmp_q;
  logic [CW-1:0] period_q;
  logic          armed;

  int vecs  = 0;
  int fails = 0;
  bit done  = 1'b0;

  always #2.5 clk = ~clk;

  evt_chan #(.CW(CW)) u_evt_chan (
    .clk(clk), .rst_n(rst_n), .glb_en(glb_en), .counter(counter),
    .cfg_periodic(cfg_periodic), .cfg_narrow(cfg_narrow), .arm_set(arm_set),
    .wr_lo(wr_lo), .wr_hi(wr_hi), .wr_data(wr_data), .expire(expire),
    .cmp_q(cmp_q), .period_q(period_q), .armed(armed)
  );

  task automatic tick();
    @(posedge clk);
    #1;
  endtask

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    vecs++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic do_reset();
    rst_n = 1'b0; glb_en = 1'b0; counter = '0; cfg_periodic = 1'b0;
    cfg_narrow = 1'b0; arm_set = 1'b0; wr_lo = 1'b0; wr_hi = 1'b0; wr_data = '0;
    tick(); tick();
    rst_n = 1'b1;
    tick();
  endtask

  task automatic wr(input bit hi, input logic [HW-1:0] d);
    wr_lo = !hi; wr_hi = hi; wr_data = d;
    tick();
    wr_lo = 1'b0; wr_hi = 1'b0;
  endtask

  task automatic arm();
    arm_set = 1'b1;
    tick();
    arm_set = 1'b0;
  endtask

  // Sweep counter from a to b; strobe expected only where counter == hit_at
  task automatic sweep(input string req, input int a, input int b, input int hit_at);
    for (int c = a; c <= b; c++) begin
      counter = c[CW-1:0];
      tick();
      chk(req, {31'b0, expire}, {31'b0, (c == hit_at)});
    end
  endtask

  // Periodic setup: comparator 0x0010, period p, channel disabled
  task automatic periodic_setup(input int p);
    do_reset();
    cfg_periodic = 1'b1;
    arm(); wr(1'b0, 8'h10);
    arm(); wr(1'b1, 8'h00);
    if (p != 0) wr(1'b0, p[HW-1:0]);
  endtask

  initial begin
    int cnt;
    do_reset();
    // R1: reset state
    chk("R1 expire", {31'b0, expire}, 0);
    chk("R1 cmp", {16'b0, cmp_q}, 32'hFFFF);
    chk("R1 period", {16'b0, period_q}, 0);
    chk("R1 armed", {31'b0, armed}, 0);

    // R2: unprogrammed comparator never fires
    glb_en = 1'b1;
    sweep("R2 unprogrammed", 0, 511, -1);

    // R4: one-shot writes go to comparator; R3 single strobe at match
    do_reset();
    wr(1'b0, 8'h40);
    chk("R4 lo to cmp", {16'b0, cmp_q}, 32'hFF40);
    wr(1'b1, 8'h00);
    chk("R4 hi to cmp", {16'b0, cmp_q}, 32'h0040);
    chk("R4 period untouched", {16'b0, period_q}, 0);
    glb_en = 1'b1;
    sweep("R3 one-shot match", 0, 'h60, 'h40);

    // R3: several targets
    for (int t = 8; t < 200; t += 37) begin
      do_reset();
      wr(1'b0, t[7:0]); wr(1'b1, 8'h00);
      glb_en = 1'b1;
      sweep("R3 target sweep", 0, 220, t);
    end

    // R5: signed wide compare
    do_reset();
    wr(1'b0, 8'h40); wr(1'b1, 8'h00);
    glb_en = 1'b1;
    counter = 16'h8041; tick();
    chk("R5 far-ahead counter no match", {31'b0, expire}, 0);
    counter = 16'h0041; tick();
    chk("R5 match after return", {31'b0, expire}, 1);

    // R6 set-value flag
    do_reset();
    cfg_periodic = 1'b1;
    arm();
    chk("R6 armed after arm_set", {31'b0, armed}, 1);
    wr(1'b0, 8'h22);
    chk("R6 armed write hits cmp", {16'b0, cmp_q}, 32'hFF22);
    chk("R6 flag cleared", {31'b0, armed}, 0);
    wr(1'b0, 8'h05);
    chk("R4 periodic unarmed to period", {16'b0, period_q}, 32'h0005);
    chk("R4 cmp kept", {16'b0, cmp_q}, 32'hFF22);

    // R7 periodic sweep over periods 1..6
    for (int p = 1; p <= 6; p++) begin
      periodic_setup(p);
      glb_en = 1'b1;
      for (int c = 0; c < 'h80; c++) begin
        counter = c[CW-1:0];
        tick();
        chk("R7 periodic strobe", {31'b0, expire},
            {31'b0, (c >= 16) && (((c - 16) % p) == 0)});
      end
    end

    // R7 catch-up after a jump
    periodic_setup(4);
    glb_en = 1'b1;
    counter = 16'h0031;
    cnt = 0;
    for (int i = 0; i < 12; i++) begin
      tick();
      if (expire) cnt++;
    end
    chk("R7 catch-up single strobe", cnt, 1);
    chk("R7 catch-up phase", {16'b0, cmp_q}, 32'h0034);

    // R7 zero period leaves comparator
    periodic_setup(0);
    glb_en = 1'b1;
    counter = 16'h0031;
    cnt = 0;
    for (int i = 0; i < 5; i++) begin
      tick();
      if (expire) cnt++;
    end
    chk("R7 zero period strobes", cnt, 1);
    chk("R7 zero period cmp", {16'b0, cmp_q}, 32'h0010);

    // R8 clamp
    do_reset();
    cfg_periodic = 1'b1;
    wr(1'b1, 8'hFF); wr(1'b0, 8'hFF);
    chk("R8 wide clamp", {16'b0, period_q}, 32'h7FFF);
    cfg_narrow = 1'b1;
    wr(1'b0, 8'hFF);
    chk("R8 narrow clamp", {16'b0, period_q}, 32'h007F);

    // R9 truncation on entering narrow mode
    do_reset();
    wr(1'b0, 8'hCD); wr(1'b1, 8'hAB);
    cfg_periodic = 1'b1;
    wr(1'b0, 8'h35); wr(1'b1, 8'h12);
    chk("R9 period before", {16'b0, period_q}, 32'h1235);
    cfg_narrow = 1'b1; tick();
    chk("R9 cmp truncated", {16'b0, cmp_q}, 32'h00CD);
    chk("R9 period truncated", {16'b0, period_q}, 32'h0035);
    cfg_periodic = 1'b0;
    wr(1'b1, 8'h55);
    chk("R9 hi write dropped", {16'b0, cmp_q}, 32'h00CD);

    // R10 narrow compare on low halves
    do_reset();
    cfg_narrow = 1'b1;
    wr(1'b0, 8'h30);
    glb_en = 1'b1;
    counter = 16'h1229; tick();
    chk("R10 narrow no match", {31'b0, expire}, 0);
    counter = 16'h1230; tick();
    chk("R10 narrow match", {31'b0, expire}, 1);

    // R11 wrap strobe
    do_reset();
    cfg_narrow = 1'b1;
    wr(1'b0, 8'h40);
    glb_en = 1'b1;
    sweep("R11 narrow one-shot wrap", 'hF0, 'h105, 'hFF);
    do_reset();
    cfg_narrow = 1'b1; cfg_periodic = 1'b1;
    arm(); wr(1'b0, 8'h40); wr(1'b0, 8'h10);
    glb_en = 1'b1;
    sweep("R11 no wrap in periodic", 'hF0, 'h105, -1);
    do_reset();
    wr(1'b0, 8'h00); wr(1'b1, 8'h40);
    glb_en = 1'b1;
    sweep("R11 no wrap in wide", 'hF0, 'h105, -1);

    // R12 global enable gating
    do_reset();
    wr(1'b0, 8'h40); wr(1'b1, 8'h00);
    sweep("R12 disabled silent", 'h30, 'h50, -1);
    glb_en = 1'b1; tick();
    chk("R12 fires on enable", {31'b0, expire}, 1);
    tick();
    chk("R12 single strobe", {31'b0, expire}, 0);

    // R13 comparator write re-arms
    wr(1'b0, 8'h45);
    chk("R13 write cycle", {31'b0, expire}, 0);
    chk("R13 new cmp", {16'b0, cmp_q}, 32'h0045);
    tick();
    chk("R13 refire", {31'b0, expire}, 1);

    if (!done) begin
      done = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", vecs, fails);
      $finish;
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      fails++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("== %0d vectors applied, %0d miscompares ==", vecs, fails);
      $finish;
    end
  end
endmodule